// File: doc/BRIEF.md
# Reference Clock Selection Controller

This block decides which of four reference clocks feeds a downstream frequency synthesizer. It watches each reference with an edge-activity monitor that runs on a fast system clock, keeps a sticky loss-of-signal alarm per reference, and picks one reference at a time. The choice comes either from a two-bit manual select, which is debounced before it is used, or from an automatic failover policy that works in one of two ways. In the revertive policy the block returns to a better reference once that reference has stayed healthy. In the non-revertive policy it keeps its current reference until that reference fails.

Reference 2 can also be disqualified by an external frequency-offset flag pair. A control input enables this and picks one of two threshold classes. When no eligible reference is left, the block stops indicating an active reference and raises a holdover request, so the synthesizer freezes near its last good frequency. After reset is released the block stays quiet for a calibration interval before it makes any selection. The three-level mode and offset controls arrive here already decoded into two-bit codes.

Top module: `clksel_ctrl`

## Requirements
- R1: While `rst_n` is low (synchronous), and for CAL_CYC (default 32) clocks after it goes high, `active_o`, `holdover_o`, `alarm_o` and `alarm_shared_o` are all 0.
- R2: With `mode_i` = 2'b00 (manual), the debounced `man_sel_i` value k selects reference k+1: 00→`active_o`=0001, 01→0010, 10→0100, 11→1000 (bit 0 is reference 1).
- R3: A new `man_sel_i` value takes effect only after it has been stable for DEB_CYC (default 16) clocks; a change that lasts fewer clocks is ignored.
- R4: A reference that shows no edge during a window of WIN_CYC (default 16) system clocks is declared lost at that window's end.
- R5: A lost reference's alarm stays high until GOOD_WIN (default 3) consecutive windows with edges have been seen.
- R6: The alarms of references 1 to 3 appear on `alarm_o[2:0]`; the alarm of reference 4 appears on `alarm_shared_o`.
- R7: In automatic modes (`mode_i` = 01 non-revertive, 10 revertive, 11 treated as 01), when the current reference is unusable the block selects the usable reference with the lowest number.
- R8: In non-revertive mode the block keeps its current reference while that reference stays usable, even when a lower-numbered one recovers.
- R9: In revertive mode the block switches to a lower-numbered usable reference only after that reference has been the best candidate for REVERT_CYC (default 64) consecutive clocks.
- R10: `fos_ctl_i` = 00 ignores the offset flags; 01 marks reference 2 unusable while `fos_flag_i[0]` is high; 10 does so on `fos_flag_i[1]`; 11 behaves as 01.
- R11: `holdover_o` is high exactly when no usable reference is selected (after calibration), and `active_o` is then all zero; otherwise `active_o` is one-hot. In manual mode, a selected reference that is unusable causes holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the monitors and control logic |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_clk_i | input | 4 | The four reference clocks, bit 0 is reference 1 |
| mode_i | input | 2 | Selection policy: 00 manual, 01 auto non-revertive, 10 auto revertive, 11 as 01 |
| man_sel_i | input | 2 | Manual reference select code |
| fos_ctl_i | input | 2 | Offset qualifier for reference 2: 00 off, 01 class A, 10 class B |
| fos_flag_i | input | 2 | Offset flags of reference 2: bit 0 class A, bit 1 class B |
| active_o | output | 4 | One-hot indicator of the reference feeding the synthesizer |
| holdover_o | output | 1 | Request to hold the synthesizer frequency |
| alarm_o | output | 3 | Sticky loss alarms of references 1 to 3 |
| alarm_shared_o | output | 1 | Shared alarm carrying reference 4 loss |

## Verification
The bench targets the recovery corner, where a block that clears its alarm on the first good window, or that reverts without a qualification delay, would show the recovered reference at the early sample point. It checks non-revertive stickiness after a recovery, which a design that ignores the mode would break by jumping back to reference 1. It drives a short glitch on the manual select, which an undebounced design would follow. It walks the offset-control codes with both flags in different combinations, so a design that decodes the wrong flag or ignores the control would stay on reference 2 or leave it at the wrong time. It also covers the all-lost case, where a design without holdover would leave a stale one-hot indicator.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  typedef enum logic [1:0] {
    SM_MANUAL   = 2'b00,
    SM_AUTO_NR  = 2'b01,
    SM_AUTO_REV = 2'b10,
    SM_SPARE    = 2'b11
  } sel_mode_e;

  typedef enum logic [1:0] {
    FQ_OFF   = 2'b00,
    FQ_CLS_A = 2'b01,
    FQ_CLS_B = 2'b10,
    FQ_SPARE = 2'b11
  } fos_ctl_e;

endpackage

// File: rtl/clksel_act_mon.sv
module clksel_act_mon #(
  parameter int GOOD_WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic win_end_i,
  output logic los_o
);
  localparam int GW = $clog2(GOOD_WIN + 1);

  logic [2:0]    sync_q;
  logic          seen_q;
  logic [GW-1:0] good_q;
  logic          edge_now;
  logic          win_active;

  assign edge_now   = sync_q[2] ^ sync_q[1];
  assign win_active = seen_q | edge_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
      good_q <= '0;
      los_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[1:0], ref_i};
      if (win_end_i) begin
        seen_q <= 1'b0;
        if (!win_active) begin
          los_o  <= 1'b1;
          good_q <= '0;
        end else if (los_o) begin
          if (good_q == GW'(GOOD_WIN - 1)) begin
            los_o  <= 1'b0;
            good_q <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
      end else if (edge_now) begin
        seen_q <= 1'b1;
      end
    end
  end

  AST_LOS_RISE_AT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_o) |-> $past(win_end_i)); // R4
  AST_LOS_FALL_AT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_o) |-> $past(win_end_i)); // R5

endmodule

// File: rtl/clksel_sel_deb.sv
module clksel_sel_deb #(
  parameter int W       = 2,
  parameter int DEB_CYC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sel_o
);
  localparam int CW = $clog2(DEB_CYC);

  logic [W-1:0]  meta_q;
  logic [W-1:0]  sync_q;
  logic [W-1:0]  cand_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      cand_q <= '0;
      cnt_q  <= '0;
      sel_o  <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      if (sync_q != cand_q) begin
        cand_q <= sync_q;
        cnt_q  <= '0;
      end else if (cnt_q != CW'(DEB_CYC - 1)) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        sel_o <= cand_q;
      end
    end
  end

  AST_DEB_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_o) |-> ($past(sync_q) == sel_o)); // R3

endmodule

// File: rtl/clksel_sel_fsm.sv
module clksel_sel_fsm
  import clksel_pkg::*;
#(
  parameter int N_IN       = 4,
  parameter int CAL_CYC    = 32,
  parameter int REVERT_CYC = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_i,
  input  logic [$clog2(N_IN)-1:0] man_sel_i,
  input  logic [N_IN-1:0]         usable_i,
  output logic [N_IN-1:0]         active_o,
  output logic                    holdover_o,
  output logic                    cal_busy_o
);
  localparam int IW  = $clog2(N_IN);
  localparam int CCW = $clog2(CAL_CYC + 1);
  localparam int RCW = $clog2(REVERT_CYC);

  logic [CCW-1:0] cal_cnt_q;
  logic [IW-1:0]  cur_idx_q, nxt_idx;
  logic           cur_vld_q, nxt_vld;
  logic [IW-1:0]  q_idx_q, nxt_q_idx;
  logic [RCW-1:0] q_cnt_q, nxt_q_cnt;
  logic [IW-1:0]  best_idx;
  logic           any_ok;
  logic           cur_ok;
  logic           is_manual, is_rev;
  logic [N_IN-1:0] nxt_act;

  assign is_manual = (mode_i == SM_MANUAL);
  assign is_rev    = (mode_i == SM_AUTO_REV);
  assign cur_ok    = cur_vld_q && usable_i[cur_idx_q];

  // lowest-numbered usable reference wins
  always_comb begin
    best_idx = '0;
    any_ok   = 1'b0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (usable_i[i]) begin
        best_idx = IW'(i);
        any_ok   = 1'b1;
      end
    end
  end

  always_comb begin
    nxt_idx   = cur_idx_q;
    nxt_vld   = cur_vld_q;
    nxt_q_idx = q_idx_q;
    nxt_q_cnt = '0;
    if (is_manual) begin
      nxt_idx = man_sel_i;
      nxt_vld = usable_i[man_sel_i];
    end else if (!cur_ok) begin
      nxt_idx = best_idx;
      nxt_vld = any_ok;
    end else if (is_rev && any_ok && (best_idx < cur_idx_q)) begin
      if (best_idx != q_idx_q) begin
        nxt_q_idx = best_idx;
      end else if (q_cnt_q == RCW'(REVERT_CYC - 1)) begin
        nxt_idx = best_idx;
      end else begin
        nxt_q_cnt = q_cnt_q + 1'b1;
      end
    end
    nxt_act = '0;
    if (nxt_vld) nxt_act[nxt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_cnt_q  <= '0;
      cal_busy_o <= 1'b1;
      cur_idx_q  <= '0;
      cur_vld_q  <= 1'b0;
      q_idx_q    <= '0;
      q_cnt_q    <= '0;
      active_o   <= '0;
      holdover_o <= 1'b0;
    end else if (cal_busy_o) begin
      cal_cnt_q <= cal_cnt_q + 1'b1;
      if (cal_cnt_q == CCW'(CAL_CYC - 1)) cal_busy_o <= 1'b0;
      active_o   <= '0;
      holdover_o <= 1'b0;
    end else begin
      cur_idx_q  <= nxt_idx;
      cur_vld_q  <= nxt_vld;
      q_idx_q    <= nxt_q_idx;
      q_cnt_q    <= nxt_q_cnt;
      active_o   <= nxt_act;
      holdover_o <= !nxt_vld;
    end
  end

  AST_CAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cal_busy_o) |-> (active_o == '0 && !holdover_o)); // R1
  AST_HOLD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    holdover_o |-> (active_o == '0)); // R11
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cal_busy_o) && !holdover_o) |-> $onehot(active_o)); // R11
  AST_NONREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cal_busy_o) && $past(mode_i) == SM_AUTO_NR && $past(|(active_o & usable_i)))
      |-> (active_o == $past(active_o))); // R8

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int N_IN       = 4,
  parameter int WIN_CYC    = 16,
  parameter int GOOD_WIN   = 3,
  parameter int DEB_CYC    = 16,
  parameter int CAL_CYC    = 32,
  parameter int REVERT_CYC = 64,
  parameter int FOS_IDX    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         ref_clk_i,
  input  logic [1:0]              mode_i,
  input  logic [$clog2(N_IN)-1:0] man_sel_i,
  input  logic [1:0]              fos_ctl_i,
  input  logic [1:0]              fos_flag_i,
  output logic [N_IN-1:0]         active_o,
  output logic                    holdover_o,
  output logic [N_IN-2:0]         alarm_o,
  output logic                    alarm_shared_o
);
  localparam int IW = $clog2(N_IN);
  localparam int WW = $clog2(WIN_CYC);

  logic [WW-1:0]   win_cnt_q;
  logic            win_end;
  logic [N_IN-1:0] los;
  logic [N_IN-1:0] usable;
  logic            fos_bad;
  logic [IW-1:0]   man_sel_db;
  logic            cal_busy;

  assign win_end = (win_cnt_q == WW'(WIN_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || win_end) win_cnt_q <= '0;
    else                   win_cnt_q <= win_cnt_q + 1'b1;
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_mon
    clksel_act_mon #(.GOOD_WIN(GOOD_WIN)) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_i     (ref_clk_i[g]),
      .win_end_i (win_end),
      .los_o     (los[g])
    );
  end

  always_comb begin
    unique case (fos_ctl_i)
      FQ_OFF:   fos_bad = 1'b0;
      FQ_CLS_B: fos_bad = fos_flag_i[1];
      default:  fos_bad = fos_flag_i[0];
    endcase
    usable = ~los;
    if (fos_bad) usable[FOS_IDX] = 1'b0;
  end

  clksel_sel_deb #(.W(IW), .DEB_CYC(DEB_CYC)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (man_sel_i),
    .sel_o (man_sel_db)
  );

  clksel_sel_fsm #(
    .N_IN       (N_IN),
    .CAL_CYC    (CAL_CYC),
    .REVERT_CYC (REVERT_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .man_sel_i  (man_sel_db),
    .usable_i   (usable),
    .active_o   (active_o),
    .holdover_o (holdover_o),
    .cal_busy_o (cal_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || cal_busy) begin
      alarm_o        <= '0;
      alarm_shared_o <= 1'b0;
    end else begin
      alarm_o        <= los[N_IN-2:0];
      alarm_shared_o <= los[N_IN-1];
    end
  end

  AST_ALARM_TRACKS_LOS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cal_busy) && $past(los[N_IN-1])) |-> alarm_shared_o); // R6

endmodule

// File: tb/clksel_ctrl_tb.sv
module clksel_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ref_en = 4'b1111;
  logic       ref_bit [4];
  logic [3:0] ref_clk;
  logic [1:0] mode = 2'b01;
  logic [1:0] man_sel = 2'b00;
  logic [1:0] fos_ctl = 2'b00;
  logic [1:0] fos_flag = 2'b00;
  logic [3:0] active;
  logic       holdover;
  logic [2:0] alarm;
  logic       alarm_sh;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_ref
    initial begin
      ref_bit[g] = 1'b0;
      forever begin
        #(12 + 4 * g);
        if (ref_en[g]) ref_bit[g] = ~ref_bit[g];
      end
    end
    assign ref_clk[g] = ref_bit[g];
  end

  clksel_ctrl u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .ref_clk_i      (ref_clk),
    .mode_i         (mode),
    .man_sel_i      (man_sel),
    .fos_ctl_i      (fos_ctl),
    .fos_flag_i     (fos_flag),
    .active_o       (active),
    .holdover_o     (holdover),
    .alarm_o        (alarm),
    .alarm_shared_o (alarm_sh)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(4);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    ref_en = 4'b0000;
    mode = 2'b01;
    @(negedge clk);
    rst_n = 1'b0;
    cyc(3);
    check("R1 reset active", int'(active), 0);
    check("R1 reset holdover", int'(holdover), 0);
    rst_n = 1'b1;
    cyc(20);
    check("R1 calib active", int'(active), 0);
    check("R1 calib holdover", int'(holdover), 0);
    check("R1 calib alarm", int'(alarm), 0);
    cyc(40);
    check("R11 holdover all lost", int'(holdover), 1);
    check("R6 alarms 1-3", int'(alarm), 7);
    check("R6 shared alarm ref4", int'(alarm_sh), 1);
  endtask

  task automatic t_manual();
    ref_en = 4'b1111;
    mode = 2'b00;
    man_sel = 2'b00;
    do_reset();
    cyc(100);
    check("R2 sel 00", int'(active), 1);
    man_sel = 2'b01; cyc(30);
    check("R2 sel 01", int'(active), 2);
    man_sel = 2'b10; cyc(30);
    check("R2 sel 10", int'(active), 4);
    man_sel = 2'b11; cyc(30);
    check("R2 sel 11", int'(active), 8);
    ref_en = 4'b0111; cyc(60);
    check("R11 manual lost holdover", int'(holdover), 1);
    check("R11 manual lost active", int'(active), 0);
    ref_en = 4'b1111; cyc(100);
  endtask

  task automatic t_debounce();
    man_sel = 2'b00; cyc(30);
    check("R3 settle", int'(active), 1);
    man_sel = 2'b10; cyc(5);
    man_sel = 2'b00; cyc(30);
    check("R3 glitch ignored", int'(active), 1);
    man_sel = 2'b01; cyc(10);
    check("R3 not yet applied", int'(active), 1);
    cyc(20);
    check("R3 applied after stable", int'(active), 2);
  endtask

  task automatic t_los();
    mode = 2'b01;
    ref_en = 4'b1111;
    do_reset();
    cyc(100);
    check("R4 no alarm when running", int'(alarm), 0);
    ref_en = 4'b1101; cyc(50);
    check("R4 ref2 lost", int'(alarm), 2);
    ref_en = 4'b1111; cyc(20);
    check("R5 alarm still sticky", int'(alarm), 2);
    cyc(80);
    check("R5 alarm cleared", int'(alarm), 0);
    ref_en = 4'b0111; cyc(50);
    check("R6 ref4 on shared", int'(alarm_sh), 1);
    check("R6 ref4 not on dedicated", int'(alarm), 0);
    ref_en = 4'b1111; cyc(100);
  endtask

  task automatic t_auto_nr();
    mode = 2'b01;
    ref_en = 4'b1111;
    do_reset();
    cyc(100);
    check("R7 start on ref1", int'(active), 1);
    ref_en = 4'b1110; cyc(50);
    check("R7 fail to ref2", int'(active), 2);
    ref_en = 4'b1111; cyc(300);
    check("R8 stays on ref2", int'(active), 2);
    ref_en = 4'b0000; cyc(60);
    check("R11 all lost holdover", int'(holdover), 1);
    check("R11 all lost active", int'(active), 0);
    ref_en = 4'b1000; cyc(100);
    check("R7 only ref4 recovers", int'(active), 8);
    ref_en = 4'b1001; cyc(300);
    check("R8 no return to ref1", int'(active), 8);
  endtask

  task automatic t_auto_rev();
    mode = 2'b10;
    ref_en = 4'b1111;
    do_reset();
    cyc(100);
    check("R7 rev start ref1", int'(active), 1);
    ref_en = 4'b1110; cyc(50);
    check("R7 rev fail to ref2", int'(active), 2);
    ref_en = 4'b1111; cyc(60);
    check("R9 qualification pending", int'(active), 2);
    cyc(190);
    check("R9 reverted to ref1", int'(active), 1);
  endtask

  task automatic t_fos();
    mode = 2'b10;
    fos_ctl = 2'b00;
    fos_flag = 2'b11;
    ref_en = 4'b1110;
    do_reset();
    cyc(150);
    check("R10 ctl off ignores flags", int'(active), 2);
    fos_ctl = 2'b01; cyc(10);
    check("R10 class A flag drops ref2", int'(active), 4);
    fos_ctl = 2'b10; fos_flag = 2'b01; cyc(150);
    check("R10 class B ignores flag0", int'(active), 2);
    fos_flag = 2'b10; cyc(10);
    check("R10 class B flag drops ref2", int'(active), 4);
    fos_ctl = 2'b00; fos_flag = 2'b00;
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_manual();
    t_debounce();
    t_los();
    t_auto_nr();
    t_auto_rev();
    t_fos();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule